// File: doc/BRIEF.md
# Aging Counter Page Victim Selector

This block picks which page frame to evict when a new page has to be brought in. It keeps a small history counter and a "used" flag for each of a fixed set of frames. The flag records whether the frame was touched since the last sample. On each periodic sample pulse, every counter moves one place toward its least significant end. The flag goes into the vacated top bit, and then the flag is cleared. Frames used recently therefore hold large counters, and frames that have sat idle decay toward zero. This approximates least-recently-used order using a few bits per frame.

Software or a miss handler reports accesses by frame number. It signals the refill of a frame once a new page has been placed there, and asks for a victim when it needs a free frame. The answer is the frame whose counter is smallest, together with that counter value. Both are registered and qualified by a one-cycle valid strobe.

Top module: `pg_age_victim`

## Requirements
- R1: After reset every counter is zero, every used flag is clear and `victim_valid` is low; a victim request issued before any other activity returns frame 0 with age 0.
- R2: An access report (`acc_valid` with frame number `acc_frame`) sets that frame's used flag at the next clock edge and leaves every other frame unchanged.
- R3: On a `tick`, each frame's counter becomes its previous value shifted right by one bit, with the previous used flag placed in the most significant bit, and the used flag is cleared. Without a tick or refill, a counter holds its value.
- R4: When an access report and a tick arrive in the same cycle for one frame, the tick shifts in the flag value held before that cycle, and the flag is set again afterwards, so the access is counted at the following tick.
- R5: A refill (`fill_valid` with frame number `fill_frame`) sets that frame's counter to zero and its used flag to one. A refill takes precedence over a tick in the same cycle for that frame.
- R6: The victim is the frame whose counter, as held in the cycle of the request, is the smallest of all frames.
- R7: When several frames share the smallest counter, the lowest-numbered of them is returned.
- R8: `victim_valid` is high for exactly the cycle following each cycle in which `victim_req` is high, and low otherwise; `victim_frame` and `victim_age` are stable while no request is made.
- R9: `victim_age` reports the counter value of the returned frame as held in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access report strobe |
| acc_frame | input | IDX_W | Frame number of the reported access |
| fill_valid | input | 1 | Refill strobe for a newly loaded page |
| fill_frame | input | IDX_W | Frame number being refilled |
| tick | input | 1 | Periodic aging pulse |
| victim_req | input | 1 | Request for an eviction candidate |
| victim_valid | output | 1 | Result strobe, one cycle after a request |
| victim_frame | output | IDX_W | Frame chosen for eviction |
| victim_age | output | AGE_W | Counter value of the chosen frame |

## Verification
The bench builds the block with its defaults of eight frames and eight-bit counters. This size is small enough that an arithmetic model of every counter and flag in the bench can be compared on every cycle. A directed sequence places chosen counter patterns, such as a single decayed frame, same-cycle access and tick, refill against tick, and all-equal ties, under a victim request. A long pseudo-random sweep then mixes every input combination, including colliding frame numbers. The counters reach all-zero, all-one and ties among many frames, and each request's answer is checked against the model.

// File: rtl/pg_age_pkg.sv
package pg_age_pkg;

    localparam int unsigned DEF_FRAMES = 8;
    localparam int unsigned DEF_AGE_W  = 8;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pg_age_frame.sv
module pg_age_frame #(
    parameter int unsigned AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             acc_i,
    input  logic             fill_i,
    output logic [AGE_W-1:0] age_o,
    output logic             used_o
);

    typedef struct packed {
        logic             used;
        logic [AGE_W-1:0] age;
    } frame_state_t;

    frame_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.age  = {st_q.used, st_q.age[AGE_W-1:1]};
            st_d.used = 1'b0;
        end
        if (acc_i) begin
            st_d.used = 1'b1;
        end
        if (fill_i) begin
            st_d.age  = '0;
            st_d.used = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign age_o  = st_q.age;
    assign used_o = st_q.used;

    AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> (age_o == '0) && used_o); // R5
    AST_ACC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |=> used_o); // R2
    AST_AGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !fill_i) |=> $stable(age_o)); // R3
    AST_TICK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !fill_i) |=> age_o[AGE_W-1] == $past(used_o)); // R4
    AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !acc_i && !fill_i) |=> !used_o); // R3

endmodule

// File: rtl/pg_age_min_find.sv
module pg_age_min_find #(
    parameter int unsigned NUM_FRAMES = 8,
    parameter int unsigned AGE_W      = 8,
    parameter int unsigned IDX_W      = 3
) (
    input  logic [NUM_FRAMES-1:0][AGE_W-1:0] ages_i,
    output logic [IDX_W-1:0]                 idx_o,
    output logic [AGE_W-1:0]                 age_o
);

    always_comb begin
        idx_o = '0;
        age_o = ages_i[0];
        for (int i = 1; i < NUM_FRAMES; i++) begin
            if (ages_i[i] < age_o) begin
                idx_o = IDX_W'(i);
                age_o = ages_i[i];
            end
        end
    end

endmodule

// File: rtl/pg_age_victim.sv
module pg_age_victim #(
    parameter int unsigned NUM_FRAMES = pg_age_pkg::DEF_FRAMES,
    parameter int unsigned AGE_W      = pg_age_pkg::DEF_AGE_W,
    parameter int unsigned IDX_W      = pg_age_pkg::idx_width(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_frame,
    input  logic             tick,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame,
    output logic [AGE_W-1:0] victim_age
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] frame;
        logic [AGE_W-1:0] age;
    } result_t;

    logic [NUM_FRAMES-1:0][AGE_W-1:0] ages;
    logic [NUM_FRAMES-1:0]            used;
    logic [NUM_FRAMES-1:0]            acc_hit;
    logic [NUM_FRAMES-1:0]            fill_hit;
    logic [IDX_W-1:0]                 min_idx;
    logic [AGE_W-1:0]                 min_age;
    result_t                          res_d, res_q;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        assign acc_hit[g]  = acc_valid  && (acc_frame  == IDX_W'(g));
        assign fill_hit[g] = fill_valid && (fill_frame == IDX_W'(g));

        pg_age_frame #(
            .AGE_W (AGE_W)
        ) i_frame (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .acc_i  (acc_hit[g]),
            .fill_i (fill_hit[g]),
            .age_o  (ages[g]),
            .used_o (used[g])
        );

        AST_VICTIM_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
            victim_req |=> victim_age <= $past(ages[g])); // R6
        AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            victim_req |=> (victim_frame <= IDX_W'(g)) || ($past(ages[g]) > victim_age)); // R7
    end

    pg_age_min_find #(
        .NUM_FRAMES (NUM_FRAMES),
        .AGE_W      (AGE_W),
        .IDX_W      (IDX_W)
    ) i_min (
        .ages_i (ages),
        .idx_o  (min_idx),
        .age_o  (min_age)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = victim_req;
        if (victim_req) begin
            res_d.frame = min_idx;
            res_d.age   = min_age;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign victim_valid = res_q.valid;
    assign victim_frame = res_q.frame;
    assign victim_age   = res_q.age;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req |=> victim_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_req |=> !victim_valid); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_req |=> $stable(victim_frame) && $stable(victim_age)); // R8
    AST_AGE_MATCHES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req |=> victim_age == $past(ages[min_idx])); // R9

endmodule

// File: tb/test_pg_age_victim.sv
module test_pg_age_victim;

    localparam int N = 8;
    localparam int W = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_frame = '0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_frame = '0;
    logic          tick = 1'b0;
    logic          victim_req = 1'b0;
    logic          victim_valid;
    logic [IW-1:0] victim_frame;
    logic [W-1:0]  victim_age;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_age [N];
    logic         m_used [N];

    always #5 clk = ~clk;

    pg_age_victim #(.NUM_FRAMES(N), .AGE_W(W), .IDX_W(IW)) i_pg_age_victim (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_frame    (acc_frame),
        .fill_valid   (fill_valid),
        .fill_frame   (fill_frame),
        .tick         (tick),
        .victim_req   (victim_req),
        .victim_valid (victim_valid),
        .victim_frame (victim_frame),
        .victim_age   (victim_age)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit av, input int af, input bit fv, input int ff,
                        input bit tk, input bit rq, input string tag);
        int exp_f;
        int ties;
        logic [W-1:0] exp_a;
        acc_valid  = av;  acc_frame  = IW'(af);
        fill_valid = fv;  fill_frame = IW'(ff);
        tick = tk;        victim_req = rq;
        exp_f = 0;
        for (int i = 1; i < N; i++) if (m_age[i] < m_age[exp_f]) exp_f = i;
        exp_a = m_age[exp_f];
        ties = 0;
        for (int i = 0; i < N; i++) if (m_age[i] == exp_a) ties++;
        for (int i = 0; i < N; i++) begin
            if (tk) begin
                m_age[i]  = {m_used[i], m_age[i][W-1:1]};
                m_used[i] = 1'b0;
            end
            if (av && af == i) m_used[i] = 1'b1;
            if (fv && ff == i) begin
                m_age[i]  = '0;
                m_used[i] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        chk(victim_valid == rq, "R8", {tag, " valid"}, int'(victim_valid), int'(rq));
        if (rq) begin
            chk(victim_frame == IW'(exp_f), (ties > 1) ? "R7" : "R6",
                {tag, " frame"}, int'(victim_frame), exp_f);
            chk(victim_age == exp_a, "R9", {tag, " age"}, int'(victim_age), int'(exp_a));
        end
        @(negedge clk);
        acc_valid = 1'b0; fill_valid = 1'b0; tick = 1'b0; victim_req = 1'b0;
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < N; i++) begin m_age[i] = '0; m_used[i] = 1'b0; end
        repeat (3) @(negedge clk);
        chk(victim_valid == 1'b0, "R1", "valid in reset", int'(victim_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(victim_valid == 1'b0, "R1", "valid after reset", int'(victim_valid), 0);
        step(0, 0, 0, 0, 0, 1, "R1 first request");
        step(0, 0, 0, 0, 1, 0, "R1 idle tick");
        step(0, 0, 0, 0, 0, 1, "R1 flags clear");
        // R2/R3: all frames used, tick -> all 0x80
        for (int i = 0; i < N; i++) step(1, i, 0, 0, 0, 0, "R2 mark");
        step(0, 0, 0, 0, 1, 1, "R3 tick");
        step(0, 0, 0, 0, 0, 1, "R3 after tick");
        // R3: all but frame 5 used -> frame 5 alone decays to 0x40
        for (int i = 0; i < N; i++) if (i != 5) step(1, i, 0, 0, 0, 0, "R2 mark");
        step(0, 0, 0, 0, 1, 0, "R3 tick");
        step(0, 0, 0, 0, 0, 1, "R3 single decay");
        // R4: access and tick together on frame 5
        step(1, 5, 0, 0, 1, 0, "R4 collide");
        step(0, 0, 0, 0, 0, 1, "R4 old flag shifted");
        step(0, 0, 0, 0, 1, 0, "R4 kept access");
        step(0, 0, 0, 0, 0, 1, "R4 access counted");
        // R5: refill, and refill against tick
        step(0, 0, 1, 6, 0, 1, "R5 fill");
        step(0, 0, 0, 0, 0, 1, "R5 fill zero");
        step(0, 0, 1, 2, 1, 0, "R5 fill beats tick");
        step(0, 0, 0, 0, 0, 1, "R5 fill over tick");
        step(0, 0, 0, 0, 1, 1, "R5 flag from fill");
        step(0, 0, 0, 0, 0, 1, "R5 after tick");
        // R7: all counters decay to zero -> frame 0
        for (int k = 0; k < W + 1; k++) step(0, 0, 0, 0, 1, 0, "R7 decay");
        step(0, 0, 0, 0, 0, 1, "R7 all equal");
        // R8: result held without request
        step(0, 0, 0, 0, 0, 0, "R8 idle");
        chk(victim_frame == 3'd0 && victim_age == '0, "R8", "held result",
            int'(victim_age), 0);
        // Sweep mixing every input
        lfsr = 16'hACE1;
        for (int c = 0; c < 20000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[9], int'(lfsr[3:1]), lfsr[4] & lfsr[8] & lfsr[11],
                 int'(lfsr[7:5]), lfsr[12] & lfsr[13], lfsr[14], "sweep R3 R4 R5");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule